// File: doc/BRIEF.md
# FSK Character Deframer and Serial Replay

This block sits behind a 1200-baud FSK demodulator. It takes the demodulated bit stream (mark is 1, space is 0), a band-energy flag and an FSK enable. From these it produces a qualified carrier indication and a three-line serial output. The carrier flag is accepted only after the enable has settled. It is then qualified with hysteresis in both directions, and while it is not qualified every output line rests high.

With a carrier present, the block finds asynchronous characters in the stream. Each character is a low start bit, eight data bits sent least significant first, and one or more high stop bits. Each good character is replayed on a data line, under a clock the block generates itself. The clock pulses once per data bit, with its rising edge in the middle of the bit period. After the eighth bit the block drives a short low strobe that tells a downstream shift register or controller to take the byte. Idle mark time, extra stop bits and frames that fail their checks produce no clock at all.

All timing comes from a single fast system clock, nominally about 3.58 MHz, through parameters. `IN_BIT_CYC` sets the receive bit period, `OUT_BIT_CYC` the replay clock period, `CD_QUAL_CYC` the hysteresis and `EN_SETTLE_CYC` the settle time. The demodulated input is taken as already synchronous to that clock.

Top module: `fsk_byte_replayer`

## Requirements
- R1: While reset is applied and on the first cycle after it, the carrier output `cd_n`, the clock `dclk`, the data `dout` and the strobe `rdy_n` are all 1.
- R2: The energy flag is ignored until `fsk_en` has been high on EN_SETTLE_CYC consecutive clock edges. Whenever `fsk_en` is sampled low, the carrier is dropped (`cd_n`=1) on that edge and the settle count restarts.
- R3: Once settled, `cd_n` goes to 0 on the edge at which the energy flag has been sampled high on CD_QUAL_CYC consecutive edges.
- R4: A qualified carrier is released (`cd_n`=1) only when the energy flag has been sampled low on CD_QUAL_CYC+1 consecutive edges. A shorter drop leaves `cd_n` at 0.
- R5: While the carrier is unqualified, and from one cycle after it is lost, `dclk`, `dout` and `rdy_n` are held at 1 and any input frames are discarded.
- R6: A start is a 1-to-0 transition of `rx_bit`, confirmed by a low sample IN_BIT_CYC/2 edges later. Data bit i (b0 first) is sampled i+1 bit periods after that, and the stop bit one period after b7.
- R7: A frame whose stop sample is 0 is discarded and produces no clock and no strobe.
- R8: One cycle after a good stop sample, replay begins. For each of the eight bits, `dout` carries the bit (b0 first) for OUT_BIT_CYC cycles, and `dclk` is 0 for the first OUT_BIT_CYC/2 of them and 1 for the rest. This gives exactly 8 rising edges per character.
- R9: After the eighth bit period, `rdy_n` is 0 for OUT_BIT_CYC/2 cycles, with `dclk` and `dout` at 1. The lines then return to idle high.
- R10: Mark time between characters and redundant extra stop bits generate no clock pulses, and back-to-back characters are each replayed.
- R11: A low glitch that is high again at the half-bit confirmation sample is rejected without output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| fsk_en | input | 1 | FSK path enable |
| band_energy | input | 1 | Demodulator band-energy flag, 1 = sufficient |
| rx_bit | input | 1 | Demodulated bit stream, 1 = mark |
| cd_n | output | 1 | Qualified carrier, low active |
| dclk | output | 1 | Replay bit clock, idle high |
| dout | output | 1 | Replay serial data, idle high |
| rdy_n | output | 1 | Byte-ready strobe, low active |

## Verification
The assertions assume that characters never arrive faster than the replay can drain them, so a finished byte never meets a replay still in progress. They also assume that `rx_bit` and the energy flag change only on the system clock. The stimulus drives every input one time unit after a clock edge. It sends frames at the nominal bit period, with replay periods shorter than receive periods. It lets each replay finish, or deliberately kills it by dropping the carrier, before the next character could complete.

// File: rtl/fskd_pkg.sv
package fskd_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/fskd_en_settle.sv
module fskd_en_settle #(
  parameter int SETTLE_CYC = 89489
) (
  input  logic clk,
  input  logic rst,
  input  logic fsk_en,
  output logic en_ok
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !fsk_en) begin
      cnt   <= '0;
      en_ok <= 1'b0;
    end else if (!en_ok) begin
      if (cnt == CW'(SETTLE_CYC - 1)) en_ok <= 1'b1;
      else                            cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fskd_carrier_qual.sv
module fskd_carrier_qual #(
  parameter int QUAL_CYC = 28636
) (
  input  logic clk,
  input  logic rst,
  input  logic fsk_en,
  input  logic en_ok,
  input  logic energy,
  output logic cd_on
);
  localparam int CW = $clog2(QUAL_CYC + 2);
  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst || !fsk_en) begin
      run   <= '0;
      cd_on <= 1'b0;
    end else if (!cd_on) begin
      // acquisition: count consecutive qualified energy samples
      if (energy && en_ok) begin
        if (run == CW'(QUAL_CYC - 1)) begin
          cd_on <= 1'b1;
          run   <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end else begin
        run <= '0;
      end
    end else begin
      // hold: release only after more than QUAL_CYC low samples
      if (!energy) begin
        if (run == CW'(QUAL_CYC)) begin
          cd_on <= 1'b0;
          run   <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end else begin
        run <= '0;
      end
    end
  end
endmodule

// File: rtl/fskd_deframer.sv
module fskd_deframer
  import fskd_pkg::*;
#(
  parameter int BIT_CYC = 2983,
  parameter int NBITS   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cd_on,
  input  logic             rx_bit,
  output logic             byte_stb,
  output logic [NBITS-1:0] byte_q
);
  localparam int HALF = BIT_CYC / 2;
  localparam int CW   = $clog2(BIT_CYC);
  localparam int IW   = $clog2(NBITS + 1);

  rx_state_t      state;
  logic [CW-1:0]  cnt;
  logic [IW-1:0]  idx;
  logic           prev;
  logic [NBITS-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_IDLE;
      cnt      <= '0;
      idx      <= '0;
      prev     <= 1'b1;
      sh       <= '0;
      byte_stb <= 1'b0;
      byte_q   <= '0;
    end else if (!cd_on) begin
      state    <= RX_IDLE;
      cnt      <= '0;
      idx      <= '0;
      prev     <= rx_bit;
      byte_stb <= 1'b0;
    end else begin
      prev     <= rx_bit;
      byte_stb <= 1'b0;
      case (state)
        RX_IDLE: begin
          cnt <= '0;
          if (prev && !rx_bit) state <= RX_START;
        end
        RX_START: begin
          if (cnt == CW'(HALF - 1)) begin
            cnt <= '0;
            idx <= '0;
            state <= rx_bit ? RX_IDLE : RX_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt == CW'(BIT_CYC - 1)) begin
            cnt <= '0;
            sh  <= {rx_bit, sh[NBITS-1:1]};
            if (idx == IW'(NBITS - 1)) state <= RX_STOP;
            else                       idx   <= idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt == CW'(BIT_CYC - 1)) begin
            cnt   <= '0;
            state <= RX_IDLE;
            if (rx_bit) begin
              byte_stb <= 1'b1;
              byte_q   <= sh;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fskd_replay.sv
module fskd_replay #(
  parameter int OUT_CYC = 2976,
  parameter int NBITS   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cd_on,
  input  logic             byte_stb,
  input  logic [NBITS-1:0] byte_d,
  output logic             dclk,
  output logic             dout,
  output logic             rdy_n,
  output logic             busy
);
  localparam int HALF = OUT_CYC / 2;
  localparam int CW   = $clog2(OUT_CYC);
  localparam int IW   = $clog2(NBITS + 1);

  logic [CW-1:0]    cnt;
  logic [IW-1:0]    idx;
  logic [NBITS-1:0] sh;
  logic             in_rdy;

  always_ff @(posedge clk) begin
    if (rst || !cd_on) begin
      dclk   <= 1'b1;
      dout   <= 1'b1;
      rdy_n  <= 1'b1;
      busy   <= 1'b0;
      in_rdy <= 1'b0;
      cnt    <= '0;
      idx    <= '0;
      sh     <= '0;
    end else if (!busy) begin
      if (byte_stb) begin
        busy   <= 1'b1;
        in_rdy <= 1'b0;
        cnt    <= '0;
        idx    <= '0;
        dclk   <= 1'b0;
        dout   <= byte_d[0];
        sh     <= byte_d >> 1;
      end
    end else if (!in_rdy) begin
      if (cnt == CW'(OUT_CYC - 1)) begin
        cnt <= '0;
        if (idx == IW'(NBITS - 1)) begin
          in_rdy <= 1'b1;
          rdy_n  <= 1'b0;
          dout   <= 1'b1;
        end else begin
          idx  <= idx + 1'b1;
          dclk <= 1'b0;
          dout <= sh[0];
          sh   <= sh >> 1;
        end
      end else begin
        if (cnt == CW'(HALF - 1)) dclk <= 1'b1;
        cnt <= cnt + 1'b1;
      end
    end else begin
      if (cnt == CW'(HALF - 1)) begin
        cnt    <= '0;
        rdy_n  <= 1'b1;
        in_rdy <= 1'b0;
        busy   <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fsk_byte_replayer.sv
module fsk_byte_replayer #(
  parameter int IN_BIT_CYC    = 2983,
  parameter int OUT_BIT_CYC   = 2976,
  parameter int CD_QUAL_CYC   = 28636,
  parameter int EN_SETTLE_CYC = 89489,
  parameter int NBITS         = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic fsk_en,
  input  logic band_energy,
  input  logic rx_bit,
  output logic cd_n,
  output logic dclk,
  output logic dout,
  output logic rdy_n
);
  logic             en_ok;
  logic             cd_on;
  logic             byte_stb;
  logic [NBITS-1:0] byte_q;
  logic             rep_busy;

  fskd_en_settle #(.SETTLE_CYC(EN_SETTLE_CYC)) u_settle (
    .clk(clk), .rst(rst), .fsk_en(fsk_en), .en_ok(en_ok)
  );

  fskd_carrier_qual #(.QUAL_CYC(CD_QUAL_CYC)) u_cd (
    .clk(clk), .rst(rst), .fsk_en(fsk_en), .en_ok(en_ok),
    .energy(band_energy), .cd_on(cd_on)
  );

  fskd_deframer #(.BIT_CYC(IN_BIT_CYC), .NBITS(NBITS)) u_rx (
    .clk(clk), .rst(rst), .cd_on(cd_on), .rx_bit(rx_bit),
    .byte_stb(byte_stb), .byte_q(byte_q)
  );

  fskd_replay #(.OUT_CYC(OUT_BIT_CYC), .NBITS(NBITS)) u_tx (
    .clk(clk), .rst(rst), .cd_on(cd_on), .byte_stb(byte_stb),
    .byte_d(byte_q), .dclk(dclk), .dout(dout), .rdy_n(rdy_n),
    .busy(rep_busy)
  );

  assign cd_n = ~cd_on;
endmodule

// File: rtl/fsk_byte_replayer_chk.sv
module fsk_byte_replayer_chk (
  input logic clk,
  input logic rst,
  input logic fsk_en,
  input logic band_energy,
  input logic cd_n,
  input logic dclk,
  input logic dout,
  input logic rdy_n,
  input logic byte_stb,
  input logic rep_busy
);
  p_enable_low_drops_r2: assert property (@(posedge clk) disable iff (rst)
    !fsk_en |=> cd_n);

  p_acquire_needs_energy_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(cd_n) |-> ($past(band_energy) && $past(fsk_en)));

  p_release_cause_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(cd_n) |-> (!$past(band_energy) || !$past(fsk_en)));

  p_idle_without_carrier_r5: assert property (@(posedge clk) disable iff (rst)
    (cd_n && $past(cd_n)) |-> (dclk && dout && rdy_n));

  p_data_steady_at_rise_r8: assert property (@(posedge clk) disable iff (rst)
    ($rose(dclk) && !$past(cd_n)) |-> $stable(dout));

  p_no_overlap_r8: assert property (@(posedge clk) disable iff (rst)
    byte_stb |-> !rep_busy);

  p_ready_clock_high_r9: assert property (@(posedge clk) disable iff (rst)
    !rdy_n |-> (dclk && dout));

  p_ready_after_clock_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(rdy_n) |-> $past(dclk));
endmodule

bind fsk_byte_replayer fsk_byte_replayer_chk u_chk (
  .clk(clk), .rst(rst), .fsk_en(fsk_en), .band_energy(band_energy),
  .cd_n(cd_n), .dclk(dclk), .dout(dout), .rdy_n(rdy_n),
  .byte_stb(byte_stb), .rep_busy(rep_busy)
);

// File: tb/tb_fsk_byte_replayer.sv
`timescale 1ns/1ps
module tb_fsk_byte_replayer;
  localparam int IN  = 20;
  localparam int OUT = 18;
  localparam int HO  = OUT / 2;
  localparam int HI  = IN / 2;
  localparam int CD  = 40;
  localparam int EN  = 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fsk_en = 1'b0;
  logic band_energy = 1'b0;
  logic rx_bit = 1'b1;
  logic cd_n, dclk, dout, rdy_n;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  fsk_byte_replayer #(
    .IN_BIT_CYC(IN), .OUT_BIT_CYC(OUT), .CD_QUAL_CYC(CD),
    .EN_SETTLE_CYC(EN), .NBITS(8)
  ) dut (
    .clk(clk), .rst(rst), .fsk_en(fsk_en), .band_energy(band_energy),
    .rx_bit(rx_bit), .cd_n(cd_n), .dclk(dclk), .dout(dout), .rdy_n(rdy_n)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int q_p0[$];
  int q_b[$];
  int en_run = 0, run = 0;
  bit m_enok = 0, m_cd = 0;
  logic e_cd_n = 1, e_clk = 1, e_dat = 1, e_rdy = 1;

  always @(posedge clk) begin
    int c, t;
    bit cd_before, ok_before;
    c = cyc + 1;
    if (rst) begin
      en_run = 0; run = 0; m_enok = 0; m_cd = 0;
      q_p0.delete(); q_b.delete();
      e_cd_n = 1; e_clk = 1; e_dat = 1; e_rdy = 1;
    end else begin
      cd_before = m_cd;
      ok_before = m_enok;
      if (!fsk_en) begin
        en_run = 0; m_enok = 0; m_cd = 0; run = 0;
      end else begin
        en_run++;
        m_enok = (en_run >= EN);
        if (!m_cd) begin
          if (band_energy && ok_before) begin
            run++;
            if (run >= CD) begin m_cd = 1; run = 0; end
          end else run = 0;
        end else begin
          if (!band_energy) begin
            run++;
            if (run > CD) begin m_cd = 0; run = 0; end
          end else run = 0;
        end
      end
      e_cd_n = !m_cd;
      e_clk = 1; e_dat = 1; e_rdy = 1;
      if (!cd_before) begin
        q_p0.delete(); q_b.delete();
      end else begin
        while (q_p0.size() > 0 && (c - q_p0[0]) >= 8*OUT + HO) begin
          void'(q_p0.pop_front()); void'(q_b.pop_front());
        end
        if (q_p0.size() > 0 && c >= q_p0[0]) begin
          t = c - q_p0[0];
          if (t < 8*OUT) begin
            e_clk = ((t % OUT) >= HO);
            e_dat = q_b[0][t / OUT];
          end else begin
            e_rdy = 0;
          end
        end
      end
    end
  end

  // ---------------- per-clock comparison and capture ----------------
  logic last_clk = 1, last_rdy = 1;
  logic [7:0] cap = 0;
  int nbits = 0;
  int got[$];

  always @(negedge clk) begin
    if (cyc >= 1) begin
      chk("R3_R4 cd_n", cd_n, e_cd_n);
      chk("R8 dclk", dclk, e_clk);
      chk("R8 dout", dout, e_dat);
      chk("R9 rdy_n", rdy_n, e_rdy);
      if (dclk && !last_clk) begin cap = {dout, cap[7:1]}; nbits++; end
      if (!rdy_n && last_rdy) begin
        chk("R8 pulses per byte", nbits, 8);
        got.push_back(cap);
        nbits = 0;
      end
      if (cd_n) nbits = 0;
      last_clk = dclk;
      last_rdy = rdy_n;
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [7:0] b, input bit stop_ok, input int extra, input bit expect_out);
    @(posedge clk); #1;
    rx_bit = 1'b0;
    if (expect_out) begin
      q_p0.push_back(cyc + 1 + HI + 9*IN + 1);
      q_b.push_back(b);
    end
    tick(IN);
    for (int i = 0; i < 8; i++) begin
      rx_bit = b[i];
      tick(IN);
    end
    rx_bit = stop_ok;
    tick(IN * (1 + extra));
    rx_bit = 1'b1;
  endtask

  task automatic expect_bytes(input string req, input int n, input int b0, input int b1);
    chk(req, got.size(), n);
    if (n > 0 && got.size() > 0) chk(req, got[0], b0);
    if (n > 1 && got.size() > 1) chk(req, got[1], b1);
    got.delete();
  endtask

  initial begin
    tick(5);
    // R1: reset values
    chk("R1 cd_n", cd_n, 1); chk("R1 dclk", dclk, 1);
    chk("R1 dout", dout, 1); chk("R1 rdy_n", rdy_n, 1);
    rst = 1'b0;
    tick(1);
    chk("R1 after release", {cd_n, dclk, dout, rdy_n}, 4'hF);

    // R2: energy ignored during settle
    fsk_en = 1'b1; band_energy = 1'b1;
    tick(EN + CD - 5);
    chk("R2 settle holds carrier off", cd_n, 1);
    tick(20);
    chk("R3 carrier qualified", cd_n, 0);

    // R6 R8 R9: single character
    tick(15);
    send(8'hA5, 1, 0, 1);
    tick(10*OUT);
    expect_bytes("R6 single byte", 1, 8'hA5, 0);

    // R10: back-to-back, then redundant stop bits and idle mark
    send(8'h3C, 1, 0, 1);
    send(8'h81, 1, 0, 1);
    tick(10*OUT);
    expect_bytes("R10 back-to-back", 2, 8'h3C, 8'h81);
    send(8'h00, 1, 3, 1);
    tick(37);
    send(8'hFF, 1, 0, 1);
    tick(10*OUT);
    expect_bytes("R10 extra stops", 2, 8'h00, 8'hFF);

    // R7: bad stop bit
    send(8'h5A, 0, 0, 0);
    tick(10*OUT);
    expect_bytes("R7 bad stop", 0, 0, 0);

    // R11: short glitch
    rx_bit = 1'b0; tick(3); rx_bit = 1'b1;
    tick(12*IN);
    expect_bytes("R11 glitch", 0, 0, 0);

    // R4: short drop keeps carrier
    band_energy = 1'b0; tick(CD); band_energy = 1'b1;
    tick(2);
    chk("R4 short drop", cd_n, 0);
    send(8'h96, 1, 0, 1);
    tick(10*OUT);
    expect_bytes("R4 byte after short drop", 1, 8'h96, 0);

    // R4 + R5: long drop releases carrier; frames ignored
    band_energy = 1'b0; tick(CD + 3);
    chk("R4 long drop", cd_n, 1);
    send(8'h42, 1, 0, 0);
    tick(10*OUT);
    expect_bytes("R5 no carrier", 0, 0, 0);

    // R5: carrier lost during replay kills output
    band_energy = 1'b1; tick(CD + 5);
    chk("R3 reacquire", cd_n, 0);
    send(8'h6E, 1, 0, 1);
    tick(3*OUT);
    band_energy = 1'b0; tick(CD + 4);
    chk("R5 replay aborted", {dclk, dout, rdy_n}, 3'b111);
    tick(10*OUT);
    expect_bytes("R5 aborted byte", 0, 0, 0);

    // R2: enable low drops carrier, re-settle required
    band_energy = 1'b1; tick(CD + 5);
    chk("R3 reacquire 2", cd_n, 0);
    fsk_en = 1'b0; tick(2);
    chk("R2 enable low", cd_n, 1);
    fsk_en = 1'b1;
    tick(EN + CD - 3);
    chk("R2 resettle", cd_n, 1);
    tick(10);
    chk("R2 after resettle", cd_n, 0);

    tick(5);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #600000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule